// File: doc/BRIEF.md
# Prioritized Multi-Thread Microprogram Sequencer

This block produces the microcode address for every clock cycle. It runs several microprogram threads, for example a processor interpreter next to a video refill task and a disk transfer task. Each thread has its own microprogram counter, a four-entry return stack and a loop counter. A priority encoder looks at one request line per thread and decides which thread fetches next. A thread that loses the machine keeps its state in its own registers, so nothing is saved or restored when control passes between threads.

The microword in flight supplies a 3-bit micro-operation, a branch target, a condition select with an invert bit and a dispatch mask. The sequencer uses these fields to pick the next address. The choices are sequential step, jump, conditional jump, call, return, counter load, counted loop, and a multiway dispatch that ORs a masked opcode field into the target. Datapath flags and the running thread's counter-zero signal feed the condition multiplexer. A decode of the top address bit drives two active-low selects, one for each half of the address space. The `PIPE` parameter adds registers on the control inputs, so a plain unregistered memory can sit in front of the block.

Top module: `useq_sched`

## Requirements
- R1: While reset is asserted and after it is released, thread 0 is active and `uaddr_o` is 0x0000. Thread t starts at address t*0x1000.
- R2: Micro-op 0 (step) moves to the current address plus one. Micro-op 1 (jump) moves to `utgt_i`.
- R3: Micro-op 2 jumps to `utgt_i` when the selected condition XOR `cinv_i` is 1, and otherwise steps. `csel_i` picks the condition: 0 carry, 1 overflow, 2 minus, 3 zero, 4 parity (these are `flags_i` bits 0 to 4), 5 the counter of the running thread is zero, 6 always true, 7 never true.
- R4: Micro-op 3 (call) jumps to `utgt_i` and pushes the current address plus one. Micro-op 4 (return) pops that address and continues there. A return on an empty stack steps instead.
- R5: Each thread's stack holds 4 entries. A fifth call overwrites the oldest entry, so four returns then give back the four newest return addresses, newest first, and the stack is empty after them.
- R6: Micro-op 5 loads the low 8 bits of `utgt_i` into the thread's counter and steps. Micro-op 6 branches to `utgt_i` and decrements when the counter is nonzero. When the counter is zero it steps and leaves the counter at zero.
- R7: Micro-op 7 (dispatch) goes to `utgt_i` OR (`opcode_i` AND `dmask_i`), with the 4-bit field placed in the low address bits.
- R8: The thread that runs in a cycle is the highest-numbered thread whose `thr_req_i` bit was set at the previous clock edge. With no request set, thread 0 runs. `thr_o` reports the running thread.
- R9: A preempted thread resumes at the address its last executed micro-op produced, and its counter and stack are unchanged.
- R10: With split selects, `cs_n_o` is 2'b10 when address bit 15 is 0 and 2'b01 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| thr_req_i | input | NTHR | Run request, one bit per thread |
| uop_i | input | 3 | Micro-operation of the executing microword |
| utgt_i | input | AW | Branch target or counter load value |
| csel_i | input | 3 | Condition select |
| cinv_i | input | 1 | Condition invert |
| dmask_i | input | OPCW | Dispatch mask |
| opcode_i | input | OPCW | Opcode field for dispatch |
| flags_i | input | 5 | Carry, overflow, minus, zero, parity (bits 0 to 4) |
| uaddr_o | output | AW | Microcode address being fetched |
| cs_n_o | output | 2 | Active-low selects for the low and high memory halves |
| thr_o | output | TW | Thread that owns `uaddr_o` |

## Verification
The assertions assume the default unpipelined build. In that build, the control fields, opcode and flags that belong to the address on `uaddr_o` are valid and stable around the same rising edge, and the request vector is sampled only at that edge. The bench drives every input at the falling edge and reads the outputs just before it drives the next word, so nothing changes near the active edge. The bench also builds each microword from the address it expects the block to fetch, so the control fields always match the thread the block has chosen.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [2:0] {
    UOP_NEXT  = 3'd0,
    UOP_JUMP  = 3'd1,
    UOP_CJUMP = 3'd2,
    UOP_CALL  = 3'd3,
    UOP_RET   = 3'd4,
    UOP_LDCNT = 3'd5,
    UOP_LOOP  = 3'd6,
    UOP_DISP  = 3'd7
  } uop_e;

  localparam int unsigned NFLAGS    = 5;
  localparam logic [2:0]  CSEL_CNTZ = 3'd5;
  localparam logic [2:0]  CSEL_TRUE = 3'd6;

endpackage

// File: rtl/useq_prio.sv
module useq_prio #(
  parameter int unsigned N  = 3,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o
);

  // highest set index wins; nothing set selects index 0
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

endmodule

// File: rtl/useq_thread_ctx.sv
module useq_thread_ctx #(
  parameter int unsigned AW       = 16,
  parameter int unsigned SD       = 4,
  parameter int unsigned CW       = 8,
  parameter logic [AW-1:0] RST_PC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic [AW-1:0] pc_d_i,
  input  logic          push_i,
  input  logic [AW-1:0] push_d_i,
  input  logic          pop_i,
  input  logic          cnt_ld_i,
  input  logic [CW-1:0] cnt_d_i,
  input  logic          cnt_dec_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] tos_o,
  output logic          empty_o,
  output logic          cnt_zero_o
);

  localparam int unsigned SPW = (SD > 1) ? $clog2(SD) : 1;
  localparam int unsigned DW  = SPW + 1;
  localparam logic [DW-1:0] DFULL = DW'(SD);

  logic [AW-1:0]  pc_q;
  logic [AW-1:0]  stk_q [SD];
  logic [SPW-1:0] sp_q,  sp_d;
  logic [DW-1:0]  dep_q, dep_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           sp_en, cnt_en;

  assign empty_o    = (dep_q == '0);
  assign cnt_zero_o = (cnt_q == '0);
  assign tos_o      = stk_q[sp_q - 1'b1];
  assign pc_o       = pc_q;

  // next-state for stack pointer, depth and counter
  always_comb begin
    sp_d   = sp_q;
    dep_d  = dep_q;
    sp_en  = 1'b0;
    if (push_i) begin
      sp_en = 1'b1;
      sp_d  = sp_q + 1'b1;
      dep_d = (dep_q == DFULL) ? dep_q : dep_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      sp_en = 1'b1;
      sp_d  = sp_q - 1'b1;
      dep_d = dep_q - 1'b1;
    end
    cnt_en = cnt_ld_i || (cnt_dec_i && !cnt_zero_o);
    cnt_d  = cnt_ld_i ? cnt_d_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= RST_PC;
      sp_q  <= '0;
      dep_q <= '0;
      cnt_q <= '0;
    end else begin
      if (act_i)  pc_q  <= pc_d_i;
      if (sp_en)  sp_q  <= sp_d;
      if (sp_en)  dep_q <= dep_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // stack storage carries no reset
  always_ff @(posedge clk_i) begin
    if (push_i) stk_q[sp_q] <= push_d_i;
  end

endmodule

// File: rtl/useq_csdec.sv
module useq_csdec #(
  parameter int unsigned AW = 16,
  parameter bit SPLIT       = 1'b1
) (
  input  logic [AW-1:0] addr_i,
  output logic [1:0]    cs_n_o
);

  generate
    if (SPLIT) begin : g_split
      assign cs_n_o = addr_i[AW-1] ? 2'b01 : 2'b10;
    end else begin : g_single
      // one device spans the whole space; top bit leaves on the address bus
      assign cs_n_o = 2'b10;
    end
  endgenerate

endmodule

// File: rtl/useq_sched.sv
module useq_sched
  import useq_pkg::*;
#(
  parameter int unsigned NTHR   = 3,
  parameter int unsigned AW     = 16,
  parameter int unsigned SDEPTH = 4,
  parameter int unsigned CW     = 8,
  parameter int unsigned OPCW   = 4,
  parameter int unsigned STRIDE = 4096,
  parameter bit          PIPE   = 1'b0,
  parameter bit          CS_SPLIT = 1'b1,
  localparam int unsigned TW    = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NTHR-1:0] thr_req_i,
  input  logic [2:0]      uop_i,
  input  logic [AW-1:0]   utgt_i,
  input  logic [2:0]      csel_i,
  input  logic            cinv_i,
  input  logic [OPCW-1:0] dmask_i,
  input  logic [OPCW-1:0] opcode_i,
  input  logic [4:0]      flags_i,
  output logic [AW-1:0]   uaddr_o,
  output logic [1:0]      cs_n_o,
  output logic [TW-1:0]   thr_o
);

  // reset synchronizer: asynchronous assert, clocked release
  logic [1:0] rsync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  // thread arbitration
  logic [TW-1:0] win_thr;
  useq_prio #(.N(NTHR), .IW(TW)) prio_i (.req_i(thr_req_i), .idx_o(win_thr));

  // per-thread state
  logic [AW-1:0] pc_arr  [NTHR];
  logic [AW-1:0] tos_arr [NTHR];
  logic [NTHR-1:0] emp_vec, cz_vec, act_vec;

  // executing microword and its owner
  uop_e            x_op;
  logic [AW-1:0]   x_tgt;
  logic [2:0]      x_csel;
  logic            x_cinv;
  logic [OPCW-1:0] x_mask;
  logic [TW-1:0]   x_thr;
  logic [AW-1:0]   x_addr;
  logic            x_vld;

  // next-address results
  logic [AW-1:0] nxt, inc;
  logic          cond, do_push, do_pop, do_ld, do_dec;
  logic [7:0]    cond_vec;

  always_comb begin
    inc      = x_addr + 1'b1;
    cond_vec = {1'b0, 1'b1, cz_vec[x_thr], flags_i};
    cond     = cond_vec[x_csel] ^ x_cinv;
    nxt      = inc;
    do_push  = 1'b0;
    do_pop   = 1'b0;
    do_ld    = 1'b0;
    do_dec   = 1'b0;
    unique case (x_op)
      UOP_NEXT:  nxt = inc;
      UOP_JUMP:  nxt = x_tgt;
      UOP_CJUMP: nxt = cond ? x_tgt : inc;
      UOP_CALL: begin
        nxt     = x_tgt;
        do_push = 1'b1;
      end
      UOP_RET: begin
        nxt    = emp_vec[x_thr] ? inc : tos_arr[x_thr];
        do_pop = 1'b1;
      end
      UOP_LDCNT: begin
        nxt   = inc;
        do_ld = 1'b1;
      end
      UOP_LOOP: begin
        nxt    = cz_vec[x_thr] ? inc : x_tgt;
        do_dec = 1'b1;
      end
      UOP_DISP:  nxt = x_tgt | AW'(opcode_i & x_mask);
      default:   nxt = inc;
    endcase
  end

  generate
    for (genvar t = 0; t < NTHR; t++) begin : g_thr
      assign act_vec[t] = x_vld && (x_thr == TW'(t));
      useq_thread_ctx #(
        .AW(AW), .SD(SDEPTH), .CW(CW), .RST_PC(AW'(t * STRIDE))
      ) ctx_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_n),
        .act_i      (act_vec[t]),
        .pc_d_i     (nxt),
        .push_i     (act_vec[t] && do_push),
        .push_d_i   (inc),
        .pop_i      (act_vec[t] && do_pop),
        .cnt_ld_i   (act_vec[t] && do_ld),
        .cnt_d_i    (x_tgt[CW-1:0]),
        .cnt_dec_i  (act_vec[t] && do_dec),
        .pc_o       (pc_arr[t]),
        .tos_o      (tos_arr[t]),
        .empty_o    (emp_vec[t]),
        .cnt_zero_o (cz_vec[t])
      );
    end

    if (PIPE) begin : g_pipe
      // control fields registered; the word executes the cycle after its fetch
      logic [2:0]      op_q;
      logic [AW-1:0]   tgt_q;
      logic [2:0]      csel_q;
      logic            cinv_q;
      logic [OPCW-1:0] mask_q;
      logic [TW-1:0]   thr_q;
      logic [AW-1:0]   addr_q;
      logic            vld_q;
      logic [AW-1:0]   issue;

      assign issue = (vld_q && (win_thr == thr_q)) ? nxt : pc_arr[win_thr];

      always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
          op_q   <= '0;
          tgt_q  <= '0;
          csel_q <= '0;
          cinv_q <= 1'b0;
          mask_q <= '0;
          thr_q  <= '0;
          addr_q <= '0;
          vld_q  <= 1'b0;
        end else begin
          op_q   <= uop_i;
          tgt_q  <= utgt_i;
          csel_q <= csel_i;
          cinv_q <= cinv_i;
          mask_q <= dmask_i;
          thr_q  <= win_thr;
          addr_q <= issue;
          vld_q  <= 1'b1;
        end
      end

      assign x_op   = uop_e'(op_q);
      assign x_tgt  = tgt_q;
      assign x_csel = csel_q;
      assign x_cinv = cinv_q;
      assign x_mask = mask_q;
      assign x_thr  = thr_q;
      assign x_addr = addr_q;
      assign x_vld  = vld_q;
      assign uaddr_o = issue;
      assign thr_o   = win_thr;
    end else begin : g_comb
      // memory answers in the same cycle; the running thread is registered
      logic [TW-1:0] cur_q;
      always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= win_thr;
      end

      assign x_op   = uop_e'(uop_i);
      assign x_tgt  = utgt_i;
      assign x_csel = csel_i;
      assign x_cinv = cinv_i;
      assign x_mask = dmask_i;
      assign x_thr  = cur_q;
      assign x_addr = pc_arr[cur_q];
      assign x_vld  = 1'b1;
      assign uaddr_o = pc_arr[cur_q];
      assign thr_o   = cur_q;
    end
  endgenerate

  useq_csdec #(.AW(AW), .SPLIT(CS_SPLIT)) csdec_i (.addr_i(uaddr_o), .cs_n_o(cs_n_o));

endmodule

// File: rtl/useq_sched_chk.sv
module useq_sched_chk
  import useq_pkg::*;
#(
  parameter int unsigned NTHR = 3,
  parameter int unsigned AW   = 16,
  parameter int unsigned TW   = 2,
  parameter int unsigned OPCW = 4,
  parameter bit          PIPE = 1'b0
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NTHR-1:0] req,
  input logic [2:0]      uop,
  input logic [AW-1:0]   utgt,
  input logic [OPCW-1:0] dmask,
  input logic [OPCW-1:0] opcode,
  input logic [AW-1:0]   uaddr,
  input logic [TW-1:0]   thr,
  input logic [TW-1:0]   win
);

  generate
    if (!PIPE) begin : g_chk
      logic stay;
      assign stay = (win == thr);

      p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (uop == UOP_NEXT && stay) |=> (uaddr == $past(uaddr) + 1'b1));

      p_jump_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (uop == UOP_JUMP && stay) |=> (uaddr == $past(utgt)));

      p_disp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (uop == UOP_DISP && stay) |=>
          (uaddr == ($past(utgt) | AW'($past(opcode) & $past(dmask)))));

      p_top_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req[NTHR-1] |=> (thr == TW'(NTHR-1)));

      p_idle_thr0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> (thr == '0));
    end
  endgenerate

endmodule

bind useq_sched useq_sched_chk #(
  .NTHR(NTHR), .AW(AW), .TW(TW), .OPCW(OPCW), .PIPE(PIPE)
) chk_i (
  .clk    (clk_i),
  .rst_n  (rst_n),
  .req    (thr_req_i),
  .uop    (uop_i),
  .utgt   (utgt_i),
  .dmask  (dmask_i),
  .opcode (opcode_i),
  .uaddr  (uaddr_o),
  .thr    (thr_o),
  .win    (win_thr)
);

// File: tb/useq_sched_tb.sv
module useq_sched_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  MAX_CYCLES = 200000;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [2:0]  thr_req_i;
  logic [2:0]  uop_i;
  logic [15:0] utgt_i;
  logic [2:0]  csel_i;
  logic        cinv_i;
  logic [3:0]  dmask_i;
  logic [3:0]  opcode_i;
  logic [4:0]  flags_i;
  logic [15:0] uaddr_o;
  logic [1:0]  cs_n_o;
  logic [1:0]  thr_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  useq_sched dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .thr_req_i(thr_req_i), .uop_i(uop_i),
    .utgt_i(utgt_i), .csel_i(csel_i), .cinv_i(cinv_i), .dmask_i(dmask_i),
    .opcode_i(opcode_i), .flags_i(flags_i), .uaddr_o(uaddr_o),
    .cs_n_o(cs_n_o), .thr_o(thr_o)
  );

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%h expected 0x%h", rq, act, exp);
    end
  endtask

  // present one microword at the falling edge, let it execute, return at the next falling edge
  task automatic issue(input logic [2:0] op, input logic [15:0] tgt,
                       input logic [2:0] cs = 3'd0, input logic inv = 1'b0);
    uop_i  = op;
    utgt_i = tgt;
    csel_i = cs;
    cinv_i = inv;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; thr_req_i = '0; flags_i = '0; opcode_i = '0; dmask_i = '0;
    uop_i = 3'd1; utgt_i = 16'h0000; csel_i = '0; cinv_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 addr in reset", uaddr_o, 16'h0000);
    chk("R10 cs in reset", {14'd0, cs_n_o}, 16'h0002);
    chk("R1 thread in reset", {14'd0, thr_o}, 16'h0000);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R1 addr after release", uaddr_o, 16'h0000);
  endtask

  task automatic t_jump;
    issue(3'd1, 16'h0100); chk("R2 jump", uaddr_o, 16'h0100);
    issue(3'd0, 16'hFFFF); chk("R2 step", uaddr_o, 16'h0101);
    issue(3'd0, 16'h0000); chk("R2 step again", uaddr_o, 16'h0102);
  endtask

  task automatic t_cond;
    flags_i = 5'b00001;
    issue(3'd1, 16'h0200);
    issue(3'd2, 16'h0280, 3'd0);       chk("R3 carry taken", uaddr_o, 16'h0280);
    issue(3'd2, 16'h0300, 3'd1);       chk("R3 overflow clear", uaddr_o, 16'h0281);
    issue(3'd2, 16'h0300, 3'd1, 1'b1); chk("R3 inverted", uaddr_o, 16'h0300);
    flags_i = 5'b10000;
    issue(3'd2, 16'h0340, 3'd4);       chk("R3 parity taken", uaddr_o, 16'h0340);
    issue(3'd2, 16'h0380, 3'd6);       chk("R3 always", uaddr_o, 16'h0380);
    issue(3'd2, 16'h03C0, 3'd7);       chk("R3 never", uaddr_o, 16'h0381);
    flags_i = '0;
  endtask

  task automatic t_call;
    issue(3'd1, 16'h0400);
    issue(3'd3, 16'h0500); chk("R4 call", uaddr_o, 16'h0500);
    issue(3'd3, 16'h0600); chk("R4 nested call", uaddr_o, 16'h0600);
    issue(3'd4, 16'h0000); chk("R4 inner return", uaddr_o, 16'h0501);
    issue(3'd4, 16'h0000); chk("R4 outer return", uaddr_o, 16'h0401);
    issue(3'd4, 16'h0000); chk("R4 empty return steps", uaddr_o, 16'h0402);
  endtask

  task automatic t_stack_wrap;
    issue(3'd1, 16'h0700);
    for (int i = 1; i <= 5; i++) issue(3'd3, 16'h0700 + 16'(i * 16));
    chk("R5 fifth call", uaddr_o, 16'h0750);
    issue(3'd4, 16'h0); chk("R5 pop 1", uaddr_o, 16'h0741);
    issue(3'd4, 16'h0); chk("R5 pop 2", uaddr_o, 16'h0731);
    issue(3'd4, 16'h0); chk("R5 pop 3", uaddr_o, 16'h0721);
    issue(3'd4, 16'h0); chk("R5 pop 4", uaddr_o, 16'h0711);
    issue(3'd4, 16'h0); chk("R5 oldest lost, empty", uaddr_o, 16'h0712);
  endtask

  task automatic t_loop;
    issue(3'd1, 16'h0800);
    issue(3'd5, 16'h0002); chk("R6 load steps", uaddr_o, 16'h0801);
    issue(3'd2, 16'h0900, 3'd5); chk("R6 counter not zero", uaddr_o, 16'h0802);
    issue(3'd1, 16'h0801);
    issue(3'd6, 16'h0801); chk("R6 loop pass 1", uaddr_o, 16'h0801);
    issue(3'd6, 16'h0801); chk("R6 loop pass 2", uaddr_o, 16'h0801);
    issue(3'd6, 16'h0801); chk("R6 loop exit", uaddr_o, 16'h0802);
    issue(3'd2, 16'h0900, 3'd5); chk("R6 counter zero", uaddr_o, 16'h0900);
  endtask

  task automatic t_dispatch;
    issue(3'd1, 16'h0A00);
    opcode_i = 4'b1011; dmask_i = 4'b0110;
    issue(3'd7, 16'h0A00); chk("R7 masked dispatch", uaddr_o, 16'h0A02);
    opcode_i = 4'b0101; dmask_i = 4'b1111;
    issue(3'd7, 16'h0A10); chk("R7 full dispatch", uaddr_o, 16'h0A15);
    opcode_i = '0; dmask_i = '0;
  endtask

  task automatic t_threads;
    issue(3'd1, 16'h0B00);
    thr_req_i = 3'b010;
    issue(3'd0, 16'h0); chk("R8 switch to 1", uaddr_o, 16'h1000);
    chk("R8 thread id 1", {14'd0, thr_o}, 16'h0001);
    issue(3'd0, 16'h0); chk("R2 thread 1 step", uaddr_o, 16'h1001);
    thr_req_i = 3'b110;
    issue(3'd0, 16'h0); chk("R1 thread 2 entry", uaddr_o, 16'h2000);
    issue(3'd5, 16'h0005); chk("R6 thread 2 load", uaddr_o, 16'h2001);
    thr_req_i = 3'b010;
    issue(3'd1, 16'h2100); chk("R9 thread 1 resumes", uaddr_o, 16'h1002);
    thr_req_i = 3'b000;
    issue(3'd0, 16'h0); chk("R9 thread 0 resumes", uaddr_o, 16'h0B01);
    chk("R8 idle thread 0", {14'd0, thr_o}, 16'h0000);
    thr_req_i = 3'b100;
    issue(3'd0, 16'h0); chk("R9 thread 2 resumes", uaddr_o, 16'h2100);
    issue(3'd2, 16'h2200, 3'd5); chk("R9 own counter kept", uaddr_o, 16'h2101);
    thr_req_i = 3'b011;
    issue(3'd0, 16'h0); chk("R8 highest of 0 and 1", uaddr_o, 16'h1003);
  endtask

  task automatic t_chipsel;
    issue(3'd1, 16'h8005);
    chk("R10 upper addr", uaddr_o, 16'h8005);
    chk("R10 upper select", {14'd0, cs_n_o}, 16'h0001);
    issue(3'd1, 16'h7FFF);
    chk("R10 lower select", {14'd0, cs_n_o}, 16'h0002);
    thr_req_i = '0;
  endtask

  initial begin
    t_reset();
    t_jump();
    t_cond();
    t_call();
    t_stack_wrap();
    t_loop();
    t_dispatch();
    t_threads();
    t_chipsel();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule